// File: doc/BRIEF.md
# Variable Block Size SAD Processing Element

This block computes every sub-block sum of absolute differences that a 16x16 macroblock needs for one candidate reference position in variable block size motion estimation. Each clock it takes one row of four current pixels and the four co-located reference pixels. It accumulates the row differences into 4x4 primitive SADs. It then combines those primitives into the larger partitions: 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16. That gives 41 results per macroblock, each on a single output port with its partition index and a valid flag.

Pixels arrive in a fixed zig-zag order. The macroblock is walked as four 8x8 quadrants of 16 cycles each. Within a quadrant, its four primitives are visited top-left, top-right, bottom-left, bottom-right, four rows each. Each merged SAD is produced as soon as the SADs it is built from are ready. A merged result uses only the output slots that the primitive results leave free. Results are therefore spread across the macroblock time, and only one quadrant's worth of primitives is held at once, with a second set held for the quadrant before it. A new macroblock may start in the cycle right after the last pixel row of the previous one.

Top module: `vbs_sad_pe`

## Requirements
- R1: While reset is asserted, `sad_valid`, `sad_idx` and `sad_val` are all zero.
- R2: A `start` pulse seen while idle marks pixel cycle k=0. Pixel cycle k (0..63) carries row k[1:0] of primitive k[3:2] in quadrant k[5:4]. Quadrants and primitives are numbered 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right. Lane i (bits 8i+7..8i) is column i of that primitive row. Each 4x4 result equals the sum of |cur-ref| over its 16 pixels.
- R3: The 4x4 SAD of block row br and block column bc (0..3 each) has index 4*br+bc. For quadrant q and primitive p, it appears 16q+4p+4 cycles after the start cycle.
- R4: The 8x4 SAD (8 wide, 4 tall) at strip row r (0..3) and column c (0..1) has index 16+2r+c. The 4x8 SAD at row r (0..1) and column c (0..3) has index 24+4r+c. For quadrant q, the top and bottom 8x4 appear at 16q+17 and 16q+18, and the left and right 4x8 appear at 16q+19 and 16q+21.
- R5: The 8x8 SAD of quadrant q has index 32+q and appears at 16q+22.
- R6: The 16x8 SADs are top (36) at cycle 39 and bottom (37) at cycle 71. The 8x16 SADs are left (38) at cycle 55 and right (39) at cycle 73. The 16x16 SAD (40) appears at cycle 74.
- R7: Each macroblock produces exactly 41 valid outputs, one per index, and `sad_valid` is low in every other cycle.
- R8: No SAD wraps. A 16x16 block of 255 against 0 yields 65280.
- R9: A `start` pulse during the 64 pixel cycles of a macroblock is ignored and leaves its results unchanged.
- R10: A macroblock started in the cycle after the previous one's last pixel row produces correct results, and the previous macroblock's trailing results are kept intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | First pixel row of a macroblock is on the inputs this cycle |
| cur_row | input | 32 | Four current-frame pixels, lane i in bits 8i+7..8i |
| ref_row | input | 32 | Four reference pixels, same lane layout |
| sad_valid | output | 1 | A result is present this cycle |
| sad_idx | output | 6 | Partition index 0..40 |
| sad_val | output | 16 | SAD value |

## Verification
Each result has a fixed due cycle, counted from the cycle that carries the start pulse. A primitive becomes visible one register stage after its fourth row, at 16q+4p+4. A merged result becomes visible one cycle after its slot in the schedule that follows the quadrant. The 16x16 result arrives last, 74 cycles after start. A monitor samples the outputs on the falling edge and stamps each result with the rising-edge count. The expected due cycle of each of the 41 indices is derived from the formulas in the requirements. The expected value is computed straight from pixel rectangles. Every index must be found at its own due cycle, and the number of results in the macroblock window must be exactly 41. The back-to-back case checks both macroblocks where their outputs interleave.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;

  localparam int SAD_TOTAL = 41;
  localparam int IDX_W     = 6;
  localparam int ROW_LANES = 4;
  localparam int POS_W     = 6;

  typedef enum logic [2:0] {
    MK_NONE,
    MK_TOP,
    MK_BOT,
    MK_LEFT,
    MK_RIGHT,
    MK_QUAD,
    MK_PAIR,
    MK_FULL
  } merge_kind_e;

  typedef struct packed {
    merge_kind_e      kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       opa;
    logic [1:0]       opb;
  } merge_slot_t;

  // raster index of a primitive: 4 * block row + block column
  function automatic logic [IDX_W-1:0] prim_index(input logic [1:0] q,
                                                   input logic [1:0] p);
    return {2'b00, q[1], p[1], q[0], p[0]};
  endfunction

  // merged result scheduled at local step j after quadrant q finished
  function automatic merge_slot_t merge_slot(input logic [1:0] q,
                                             input logic [3:0] j);
    merge_slot_t s;
    s      = '0;
    s.kind = MK_NONE;
    case (j)
      4'd0: begin s.kind = MK_TOP;   s.idx = {2'b01, 1'b0, q[1], 1'b0, q[0]}; end
      4'd1: begin s.kind = MK_BOT;   s.idx = {2'b01, 1'b0, q[1], 1'b1, q[0]}; end
      4'd2: begin s.kind = MK_LEFT;  s.idx = {3'b011, q[1], q[0], 1'b0};      end
      4'd4: begin s.kind = MK_RIGHT; s.idx = {3'b011, q[1], q[0], 1'b1};      end
      4'd5: begin s.kind = MK_QUAD;  s.idx = {4'b1000, q};                    end
      4'd6: begin
        case (q)
          2'd1: begin s.kind = MK_PAIR; s.idx = 6'd36; s.opa = 2'd0; s.opb = 2'd1; end
          2'd2: begin s.kind = MK_PAIR; s.idx = 6'd38; s.opa = 2'd0; s.opb = 2'd2; end
          2'd3: begin s.kind = MK_PAIR; s.idx = 6'd37; s.opa = 2'd2; s.opb = 2'd3; end
          default: s.kind = MK_NONE;
        endcase
      end
      4'd8: if (q == 2'd3) begin
        s.kind = MK_PAIR; s.idx = 6'd39; s.opa = 2'd1; s.opb = 2'd3;
      end
      4'd9: if (q == 2'd3) begin
        s.kind = MK_FULL; s.idx = 6'd40;
      end
      default: s.kind = MK_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sad_seq_ctrl.sv
module sad_seq_ctrl #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             act,
  output logic [POS_W-1:0] pos,
  output logic             start_ok,
  output logic             busy
);
  localparam logic [POS_W-1:0] LAST_POS = '1;

  logic [POS_W-1:0] cnt_q;

  assign start_ok = start && !busy;
  assign act      = start_ok || busy;
  assign pos      = start_ok ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (act) begin
      cnt_q <= pos + 1'b1;
      busy  <= (pos != LAST_POS);
    end
  end
endmodule

// File: rtl/sad_row_sum.sv
module sad_row_sum #(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int SUM_W = 16
) (
  input  logic [LANES*PIX_W-1:0] cur_row,
  input  logic [LANES*PIX_W-1:0] ref_row,
  output logic [SUM_W-1:0]       row_sad
);
  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  logic [LANES-1:0][PIX_W-1:0] lane_diff;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_diff[l] = abs_diff(cur_row[l*PIX_W +: PIX_W], ref_row[l*PIX_W +: PIX_W]);
  end

  always_comb begin
    row_sad = '0;
    for (int l = 0; l < LANES; l++) begin
      row_sad = row_sad + SUM_W'(lane_diff[l]);
    end
  end
endmodule

// File: rtl/sad_prim_store.sv
module sad_prim_store #(
  parameter int SAD_W = 16,
  parameter int POS_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  act,
  input  logic [POS_W-1:0]      pos,
  input  logic [SAD_W-1:0]      row_sad,
  input  logic                  rd_bank,
  output logic                  prim_fire,
  output logic                  quad_done,
  output logic [SAD_W-1:0]      prim_val,
  output logic [3:0][SAD_W-1:0] rd_sads
);
  logic [SAD_W-1:0]           acc_q;
  logic [1:0][3:0][SAD_W-1:0] bank_q;

  assign prim_val  = ((pos[1:0] == 2'd0) ? '0 : acc_q) + row_sad;
  assign prim_fire = act && (pos[1:0] == 2'd3);
  assign quad_done = prim_fire && (pos[3:2] == 2'd3);
  assign rd_sads   = bank_q[rd_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bank_q <= '0;
    end else begin
      if (act) acc_q <= prim_val;
      if (prim_fire) bank_q[pos[4]][pos[3:2]] <= prim_val;
    end
  end
endmodule

// File: rtl/sad_merge_unit.sv
module sad_merge_unit
  import vbs_sad_pkg::*;
#(
  parameter int SAD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  quad_done,
  input  logic [1:0]            done_q,
  input  logic [3:0][SAD_W-1:0] bank_sads,
  output logic                  rd_bank,
  output logic                  mrg_fire,
  output logic [IDX_W-1:0]      mrg_idx,
  output logic [SAD_W-1:0]      mrg_val
);
  localparam logic [3:0] LAST_STEP = 4'd9;

  function automatic logic [SAD_W-1:0] add2(input logic [SAD_W-1:0] a,
                                            input logic [SAD_W-1:0] b);
    return a + b;
  endfunction

  logic                  run_q;
  logic [3:0]            step_q;
  logic [1:0]            quad_q;
  logic [3:0][SAD_W-1:0] sad8_q;
  merge_slot_t           slot;

  assign rd_bank  = quad_q[0];
  assign slot     = merge_slot(quad_q, step_q);
  assign mrg_fire = run_q && (slot.kind != MK_NONE);
  assign mrg_idx  = slot.idx;

  always_comb begin
    case (slot.kind)
      MK_TOP:   mrg_val = add2(bank_sads[0], bank_sads[1]);
      MK_BOT:   mrg_val = add2(bank_sads[2], bank_sads[3]);
      MK_LEFT:  mrg_val = add2(bank_sads[0], bank_sads[2]);
      MK_RIGHT: mrg_val = add2(bank_sads[1], bank_sads[3]);
      MK_QUAD:  mrg_val = add2(add2(bank_sads[0], bank_sads[1]),
                               add2(bank_sads[2], bank_sads[3]));
      MK_PAIR:  mrg_val = add2(sad8_q[slot.opa], sad8_q[slot.opb]);
      MK_FULL:  mrg_val = add2(add2(sad8_q[0], sad8_q[1]),
                               add2(sad8_q[2], sad8_q[3]));
      default:  mrg_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      quad_q <= '0;
      sad8_q <= '0;
    end else begin
      if (quad_done) begin
        run_q  <= 1'b1;
        step_q <= '0;
        quad_q <= done_q;
      end else if (run_q) begin
        step_q <= step_q + 1'b1;
        if (step_q == LAST_STEP) run_q <= 1'b0;
      end
      if (mrg_fire && slot.kind == MK_QUAD) sad8_q[quad_q] <= mrg_val;
    end
  end
endmodule

// File: rtl/vbs_sad_pe.sv
module vbs_sad_pe
  import vbs_sad_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ROW_LANES*PIX_W-1:0]   cur_row,
  input  logic [ROW_LANES*PIX_W-1:0]   ref_row,
  output logic                         sad_valid,
  output logic [IDX_W-1:0]             sad_idx,
  output logic [PIX_W+7:0]             sad_val
);
  localparam int SAD_W = PIX_W + 8;

  logic                  act, start_ok, busy;
  logic [POS_W-1:0]      pos;
  logic [SAD_W-1:0]      row_sad, prim_val, mrg_val;
  logic                  prim_fire, quad_done, rd_bank, mrg_fire;
  logic [3:0][SAD_W-1:0] rd_sads;
  logic [IDX_W-1:0]      mrg_idx;

  sad_seq_ctrl #(.POS_W(POS_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .act(act), .pos(pos), .start_ok(start_ok), .busy(busy)
  );

  sad_row_sum #(.PIX_W(PIX_W), .LANES(ROW_LANES), .SUM_W(SAD_W)) i_row (
    .cur_row(cur_row), .ref_row(ref_row), .row_sad(row_sad)
  );

  sad_prim_store #(.SAD_W(SAD_W), .POS_W(POS_W)) i_prim (
    .clk(clk), .rst_n(rst_n), .act(act), .pos(pos), .row_sad(row_sad),
    .rd_bank(rd_bank), .prim_fire(prim_fire), .quad_done(quad_done),
    .prim_val(prim_val), .rd_sads(rd_sads)
  );

  sad_merge_unit #(.SAD_W(SAD_W)) i_merge (
    .clk(clk), .rst_n(rst_n), .quad_done(quad_done), .done_q(pos[5:4]),
    .bank_sads(rd_sads), .rd_bank(rd_bank), .mrg_fire(mrg_fire),
    .mrg_idx(mrg_idx), .mrg_val(mrg_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_valid <= 1'b0;
      sad_idx   <= '0;
      sad_val   <= '0;
    end else begin
      sad_valid <= prim_fire || mrg_fire;
      if (prim_fire) begin
        sad_idx <= prim_index(pos[5:4], pos[3:2]);
        sad_val <= prim_val;
      end else if (mrg_fire) begin
        sad_idx <= mrg_idx;
        sad_val <= mrg_val;
      end
    end
  end
endmodule

// File: rtl/vbs_sad_pe_chk.sv
module vbs_sad_pe_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [5:0]       pos,
  input logic             prim_fire,
  input logic             mrg_fire,
  input logic             sad_valid,
  input logic [5:0]       sad_idx,
  input logic [PIX_W+7:0] sad_val
);
  localparam int PIX_MAX  = (1 << PIX_W) - 1;
  localparam int PRIM_MAX = 16 * PIX_MAX;
  localparam int FULL_MAX = 256 * PIX_MAX;

  a_r7_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(prim_fire && mrg_fire));

  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid |-> (sad_idx < 6'd41));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(prim_fire || mrg_fire) |=> !sad_valid);

  a_r3_prim_emit: assert property (@(posedge clk) disable iff (!rst_n)
    prim_fire |=> (sad_valid && sad_idx < 6'd16));

  a_r4_merge_emit: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_fire |=> (sad_valid && sad_idx >= 6'd16));

  a_r2_prim_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sad_valid && sad_idx < 6'd16) |-> (int'(sad_val) <= PRIM_MAX));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sad_valid && sad_idx == 6'd40) |-> (int'(sad_val) <= FULL_MAX));

  a_r9_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pos != 6'd63) |=> (busy && pos == $past(pos) + 6'd1));
endmodule

bind vbs_sad_pe vbs_sad_pe_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pos(pos),
  .prim_fire(prim_fire), .mrg_fire(mrg_fire),
  .sad_valid(sad_valid), .sad_idx(sad_idx), .sad_val(sad_val)
);

// File: tb/test_vbs_sad_pe.sv
`timescale 1ns/1ps
module test_vbs_sad_pe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cur_row = '0;
  logic [31:0] ref_row = '0;
  logic        sad_valid;
  logic [5:0]  sad_idx;
  logic [15:0] sad_val;

  vbs_sad_pe i_vbs_sad_pe (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_row(cur_row), .ref_row(ref_row),
    .sad_valid(sad_valid), .sad_idx(sad_idx), .sad_val(sad_val)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int log_cyc [0:511];
  int log_idx [0:511];
  int log_val [0:511];
  int log_n = 0;
  always @(negedge clk) begin
    if (rst_n && sad_valid && log_n < 512) begin
      log_cyc[log_n] = cyc;
      log_idx[log_n] = int'(sad_idx);
      log_val[log_n] = int'(sad_val);
      log_n = log_n + 1;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int px(input int seed, input bit is_ref, input int y, input int x);
    case (seed)
      0: return is_ref ? 0 : ((y * 16 + x) & 255);
      1: return is_ref ? 0 : 255;
      2: return is_ref ? ((x * 5 + y * 29 + 100) & 255) : ((x * 37 + y * 11) & 255);
      3: return is_ref ? ((y * y + 3 * x) & 255) : 0;
      default: return (x + y) & 255;
    endcase
  endfunction

  function automatic int region(input int seed, input int y0, input int x0,
                                input int h, input int w);
    int s = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) begin
        int d = px(seed, 1'b0, y, x) - px(seed, 1'b1, y, x);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  // due cycle, value and requirement tag of each index, from the requirements
  function automatic void expect_of(input int seed, input int idx,
                                    output int c, output int v, output string tag);
    if (idx < 16) begin
      int br = idx / 4, bc = idx % 4;
      int q = (br / 2) * 2 + bc / 2, p = (br % 2) * 2 + bc % 2;
      c = 16 * q + 4 * p + 4; v = region(seed, 4 * br, 4 * bc, 4, 4); tag = "R2/R3";
    end else if (idx < 24) begin
      int r = (idx - 16) / 2, k = (idx - 16) % 2;
      int q = (r / 2) * 2 + k;
      c = 16 * q + 17 + (r % 2); v = region(seed, 4 * r, 8 * k, 4, 8); tag = "R4";
    end else if (idx < 32) begin
      int r = (idx - 24) / 4, k = (idx - 24) % 4;
      int q = r * 2 + k / 2;
      c = 16 * q + 19 + 2 * (k % 2); v = region(seed, 8 * r, 4 * k, 8, 4); tag = "R4";
    end else if (idx < 36) begin
      int q = idx - 32;
      c = 16 * q + 22; v = region(seed, 8 * (q / 2), 8 * (q % 2), 8, 8); tag = "R5";
    end else begin
      tag = "R6";
      case (idx)
        36: begin c = 39; v = region(seed, 0, 0, 8, 16);  end
        37: begin c = 71; v = region(seed, 8, 0, 8, 16);  end
        38: begin c = 55; v = region(seed, 0, 0, 16, 8);  end
        39: begin c = 73; v = region(seed, 0, 8, 16, 8);  end
        default: begin c = 74; v = region(seed, 0, 0, 16, 16); end
      endcase
    end
  endfunction

  function automatic int find_at(input int when);
    for (int e = 0; e < log_n; e++) if (log_cyc[e] == when) return e;
    return -1;
  endfunction

  function automatic int count_in(input int lo, input int hi);
    int n = 0;
    for (int e = 0; e < log_n; e++) if (log_cyc[e] > lo && log_cyc[e] <= hi) n++;
    return n;
  endfunction

  task automatic drive_mb(input int seed, input bit noisy, output int s_cyc);
    s_cyc = cyc;
    for (int k = 0; k < 64; k++) begin
      int q = k >> 4, p = (k >> 2) & 3, r = k & 3;
      int y = 8 * (q >> 1) + 4 * (p >> 1) + r;
      int x0 = 8 * (q & 1) + 4 * (p & 1);
      start = (k == 0) || (noisy && (k == 20 || k == 41 || k == 63));
      for (int i = 0; i < 4; i++) begin
        cur_row[i*8 +: 8] = 8'(px(seed, 1'b0, y, x0 + i));
        ref_row[i*8 +: 8] = 8'(px(seed, 1'b1, y, x0 + i));
      end
      @(negedge clk);
    end
    start   = 1'b0;
    cur_row = '0;
    ref_row = '0;
  endtask

  task automatic check_mb(input int seed, input int s_cyc);
    for (int idx = 0; idx < 41; idx++) begin
      int c, v, e;
      string tag;
      expect_of(seed, idx, c, v, tag);
      e = find_at(s_cyc + c);
      chk(tag, $sformatf("index at cycle %0d", c), (e < 0) ? -1 : log_idx[e], idx);
      chk(tag, $sformatf("value of index %0d", idx), (e < 0) ? -1 : log_val[e], v);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sad_valid in reset", int'(sad_valid), 0);
    chk("R1", "sad_idx in reset", int'(sad_idx), 0);
    chk("R1", "sad_val in reset", int'(sad_val), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single(input int seed);
    int s;
    drive_mb(seed, 1'b0, s);
    repeat (12) @(negedge clk);
    check_mb(seed, s);
    chk("R7", "results in macroblock window", count_in(s, s + 74), 41);
    chk("R7", "results after the window", count_in(s + 74, s + 86), 0);
  endtask

  task automatic t_overflow();
    int s, e;
    drive_mb(1, 1'b0, s);
    repeat (12) @(negedge clk);
    e = find_at(s + 74);
    chk("R8", "16x16 of 255 vs 0", (e < 0) ? -1 : log_val[e], 65280);
    check_mb(1, s);
  endtask

  task automatic t_ignore_start();
    int s;
    drive_mb(2, 1'b1, s);
    repeat (12) @(negedge clk);
    check_mb(2, s);
    chk("R9", "results with stray start pulses", count_in(s, s + 86), 41);
  endtask

  task automatic t_back_to_back();
    int s1, s2;
    drive_mb(3, 1'b0, s1);
    drive_mb(0, 1'b0, s2);
    repeat (12) @(negedge clk);
    chk("R10", "second start spacing", s2 - s1, 64);
    check_mb(3, s1);
    check_mb(0, s2);
    chk("R10", "results over both macroblocks", count_in(s1, s2 + 74), 82);
  endtask

  initial begin
    t_reset();
    t_single(0);
    t_single(2);
    t_overflow();
    t_ignore_start();
    t_back_to_back();
    t_single(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule